// File: doc/BRIEF.md
# Translation Fault Logger

This block records faults reported by an address translation engine and raises an interrupt for software. When the engine pulses its fault strobe, the block loads a status word with a fixed set of error flags plus a direction flag, and it loads an address word with the failing address aligned down to its page. It then raises a level interrupt line.

Software reads and writes both words through a simple single-cycle register port. Any read or write that hits either word drops the interrupt. A write to the status word is masked, and the reserved flag in bit 23 always stays at 1. A write to the address word stores the value unchanged. Accesses to any other offset have no effect. If a fault arrives in the same cycle as a software write, the fault is captured and the interrupt stays high.

Top module: `errlog_unit`

## Requirements
- R1: After reset, status reads 0x00800000, the address word reads 0 and `irq` is low.
- R2: A write-direction fault (`fault_is_read`=0) loads status with exactly bits 31, 30, 23 and 17 set (0xC0820000) on the next clock edge.
- R3: A read-direction fault (`fault_is_read`=1) loads status with bits 31, 30, 23, 18 and 17 set (0xC0860000).
- R4: A fault loads the address word with `fault_addr` with its low PAGE_SHIFT bits (12 by default) cleared, and sets `irq` high on the next clock edge.
- R5: A read at offset 0x1000 (status) or 0x1004 (address) with no fault in the same cycle clears `irq` on the next edge.
- R6: A write at offset 0x1000 or 0x1004 with no fault in the same cycle clears `irq` on the next edge.
- R7: A software write to status stores (wdata & 0xFF0FFFFF) | 0x00800000.
- R8: A software write to the address word stores all 32 bits of wdata.
- R9: An access to any other offset changes neither register nor `irq`, and a read there returns 0.
- R10: A fault in the same cycle as a software write or read of either word wins: the fault values are captured and `irq` is high after the edge.
- R11: During a read access, `acc_rdata` shows the addressed word in the same cycle; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | One-cycle fault strobe from the translation engine |
| fault_addr | input | 32 | Address that failed translation |
| fault_is_read | input | 1 | 1 when the faulting access was a read |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (16) | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level fault interrupt |

## Verification
The assertions assume `fault_valid` is a clean strobe that is sampled at the clock and needs no handshake. They also assume register accesses complete in one cycle, so a single cycle's inputs fully decide the next state. The stimulus drives every input on the falling edge and holds it for exactly one cycle. It returns the strobes to 0 between scenarios. Coincident fault and access cycles occur only in the test that targets precedence.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam logic [31:0] ST_SUMMARY = 32'h8000_0000;
  localparam logic [31:0] ST_LATE    = 32'h4000_0000;
  localparam logic [31:0] ST_RSVD    = 32'h0080_0000;
  localparam logic [31:0] ST_DIR_RD  = 32'h0004_0000;
  localparam logic [31:0] ST_AVALID  = 32'h0002_0000;
  localparam logic [31:0] ST_WMASK   = 32'hFF0F_FFFF;

  function automatic logic [31:0] fault_status(input logic is_read);
    return ST_SUMMARY | ST_LATE | ST_RSVD | ST_AVALID | (is_read ? ST_DIR_RD : 32'h0);
  endfunction

  function automatic logic [31:0] sw_status(input logic [31:0] w);
    return (w & ST_WMASK) | ST_RSVD;
  endfunction

  function automatic logic [31:0] page_base(input logic [31:0] a, input int unsigned shift);
    return a & ~((32'd1 << shift) - 32'd1);
  endfunction
endpackage

// File: rtl/errlog_decode.sv
module errlog_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ST_OFS = 16'h1000,
  parameter logic [ADDR_W-1:0] AD_OFS = 16'h1004
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              st_wr,
  output logic              ad_wr,
  output logic              st_rd,
  output logic              ad_rd,
  output logic              touch
);
  logic hit_st, hit_ad;
  always_comb begin
    hit_st = acc_valid && (acc_addr == ST_OFS);
    hit_ad = acc_valid && (acc_addr == AD_OFS);
    st_wr  = hit_st && acc_write;
    ad_wr  = hit_ad && acc_write;
    st_rd  = hit_st && !acc_write;
    ad_rd  = hit_ad && !acc_write;
    touch  = hit_st || hit_ad;
  end
endmodule

// File: rtl/errlog_status_reg.sv
module errlog_status_reg
  import errlog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fault,
  input  logic        is_read,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= ST_RSVD;
    else if (fault)  q <= fault_status(is_read);
    else if (wr)     q <= sw_status(wdata);
  end
endmodule

// File: rtl/errlog_addr_reg.sv
module errlog_addr_reg
  import errlog_pkg::*;
#(
  parameter int PAGE_SHIFT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fault,
  input  logic [31:0] fault_addr,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (fault)  q <= page_base(fault_addr, PAGE_SHIFT);
    else if (wr)     q <= wdata;
  end
endmodule

// File: rtl/errlog_irq_ctl.sv
module errlog_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (set_evt)  irq <= 1'b1;
    else if (clr_evt)  irq <= 1'b0;
  end
endmodule

// File: rtl/errlog_unit.sv
module errlog_unit #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 12,
  parameter logic [ADDR_W-1:0] ST_OFS = 16'h1000,
  parameter logic [ADDR_W-1:0] AD_OFS = 16'h1004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  logic [31:0]       fault_addr,
  input  logic              fault_is_read,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              irq
);
  logic        st_wr_evt, ad_wr_evt, st_rd_evt, ad_rd_evt, touch_evt;
  logic [31:0] status_q, addr_q;

  errlog_decode #(.ADDR_W(ADDR_W), .ST_OFS(ST_OFS), .AD_OFS(AD_OFS)) u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .st_wr(st_wr_evt), .ad_wr(ad_wr_evt), .st_rd(st_rd_evt), .ad_rd(ad_rd_evt),
    .touch(touch_evt)
  );

  errlog_status_reg u_st (
    .clk(clk), .rst_n(rst_n), .fault(fault_valid), .is_read(fault_is_read),
    .wr(st_wr_evt), .wdata(acc_wdata), .q(status_q)
  );

  errlog_addr_reg #(.PAGE_SHIFT(PAGE_SHIFT)) u_ad (
    .clk(clk), .rst_n(rst_n), .fault(fault_valid), .fault_addr(fault_addr),
    .wr(ad_wr_evt), .wdata(acc_wdata), .q(addr_q)
  );

  errlog_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(fault_valid), .clr_evt(touch_evt), .irq(irq)
  );

  always_comb begin
    acc_rdata = '0;
    if (st_rd_evt)      acc_rdata = status_q;
    else if (ad_rd_evt) acc_rdata = addr_q;
  end
endmodule

// File: rtl/errlog_chk.sv
module errlog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fault_valid,
  input logic        fault_is_read,
  input logic        touch,
  input logic        sw_st_wr,
  input logic [31:0] status_q,
  input logic        irq
);
  // R4
  fault_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> irq);
  // R5
  touch_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && !fault_valid) |=> !irq);
  // R2
  wr_fault_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !fault_is_read) |=> (status_q == 32'hC082_0000));
  // R3
  rd_fault_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_is_read) |=> (status_q == 32'hC086_0000));
  // R7
  sw_write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_st_wr && !fault_valid) |=> (status_q[23] && status_q[22:20] == 3'b000));
  // R9
  irq_only_from_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fault_valid));
endmodule

bind errlog_unit errlog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_is_read(fault_is_read),
  .touch(touch_evt), .sw_st_wr(st_wr_evt), .status_q(status_q), .irq(irq)
);

// File: tb/errlog_unit_tb.sv
module errlog_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_valid = 1'b0;
  logic [31:0] fault_addr = '0;
  logic        fault_is_read = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  errlog_unit u_dut (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_is_read(fault_is_read), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fault(input logic [31:0] a, input logic rd);
    @(negedge clk);
    fault_valid = 1'b1; fault_addr = a; fault_is_read = rd;
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    #1 rd = acc_rdata;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    access(1'b0, 16'h1000, 0, r); chk("R1 R11 status", r, 32'h0080_0000);
    access(1'b0, 16'h1004, 0, r); chk("R1 R11 addr", r, 32'h0);
  endtask

  task automatic t_write_fault();
    logic [31:0] r;
    fault(32'h1234_5678, 1'b0);
    chk("R4 irq set", {31'd0, irq}, 32'd1);
    access(1'b0, 16'h1000, 0, r); chk("R2 status", r, 32'hC082_0000);
    chk("R5 irq cleared by read", {31'd0, irq}, 32'd0);
    access(1'b0, 16'h1004, 0, r); chk("R4 addr", r, 32'h1234_5000);
  endtask

  task automatic t_read_fault();
    logic [31:0] r;
    fault(32'hFFFF_FFFF, 1'b1);
    chk("R4 irq set", {31'd0, irq}, 32'd1);
    access(1'b0, 16'h1004, 0, r); chk("R4 addr", r, 32'hFFFF_F000);
    chk("R5 irq cleared by addr read", {31'd0, irq}, 32'd0);
    access(1'b0, 16'h1000, 0, r); chk("R3 status", r, 32'hC086_0000);
  endtask

  task automatic t_sw_write();
    logic [31:0] r;
    fault(32'h0000_2000, 1'b0);
    access(1'b1, 16'h1000, 32'hFFFF_FFFF, r);
    chk("R6 irq cleared by status write", {31'd0, irq}, 32'd0);
    access(1'b0, 16'h1000, 0, r); chk("R7 masked ones", r, 32'hFF8F_FFFF);
    access(1'b1, 16'h1000, 32'h0, r);
    access(1'b0, 16'h1000, 0, r); chk("R7 reserved forced", r, 32'h0080_0000);
    fault(32'h0000_3000, 1'b1);
    access(1'b1, 16'h1004, 32'hDEAD_BEEF, r);
    chk("R6 irq cleared by addr write", {31'd0, irq}, 32'd0);
    access(1'b0, 16'h1004, 0, r); chk("R8 full addr", r, 32'hDEAD_BEEF);
  endtask

  task automatic t_other();
    logic [31:0] r;
    fault(32'h0004_5000, 1'b0);
    access(1'b1, 16'h0008, 32'h0, r);
    chk("R9 irq kept after other write", {31'd0, irq}, 32'd1);
    access(1'b0, 16'h1008, 0, r);
    chk("R9 other read data", r, 32'h0);
    chk("R9 irq kept after other read", {31'd0, irq}, 32'd1);
    access(1'b0, 16'h1000, 0, r); chk("R9 status unchanged", r, 32'hC082_0000);
    access(1'b0, 16'h1004, 0, r); chk("R9 addr unchanged", r, 32'h0004_5000);
  endtask

  task automatic t_conflict();
    logic [31:0] r;
    @(negedge clk);
    fault_valid = 1'b1; fault_addr = 32'h0ABC_D123; fault_is_read = 1'b0;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 16'h1000; acc_wdata = 32'h0;
    @(negedge clk);
    fault_valid = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    chk("R10 irq held", {31'd0, irq}, 32'd1);
    access(1'b0, 16'h1000, 0, r); chk("R10 status fault wins", r, 32'hC082_0000);
    @(negedge clk);
    fault_valid = 1'b1; fault_addr = 32'h7777_7777; fault_is_read = 1'b1;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 16'h1004; acc_wdata = 32'h1;
    @(negedge clk);
    fault_valid = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    chk("R10 irq held addr", {31'd0, irq}, 32'd1);
    access(1'b0, 16'h1004, 0, r); chk("R10 addr fault wins", r, 32'h7777_7000);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_fault();
    t_read_fault();
    t_sw_write();
    t_other();
    t_conflict();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule